// File: doc/BRIEF.md
# Latch-Based Multiport Register File

This block is a small register file for standard-cell flows, meant for storage below about a kilobit, where a compiled SRAM would cost more area than it saves. Each word is a row of level-sensitive latches instead of edge-triggered flops. The block has a parameterised number of write ports and read ports. Every write port has its own address decoder. Every read port has its own combinational multiplexer.

A write request is captured by the rising clock edge into a small set of per-port flops. During the following low phase of the clock, the decoded and prioritised request opens the addressed word's latches through a gated word enable. That enable comes from a latch and is glitch-free. Reads are combinational from the array. An optional transparent-high latch on each read output keeps the read data steady through the low phase, while the array may be changing underneath it.

Timing convention: cycle t starts at a rising edge. Inputs applied during cycle t are sampled at the rising edge that ends it. Read data for an address applied in cycle t is valid from the high phase of cycle t.

Top module: `latch_regfile`

## Requirements
- R1: Visibility of writes. A write issued in cycle t is returned by reads of that word issued in cycle t+2 and in every later cycle, until the word is written again.
- R2: Read during write. A read of a word issued in the same cycle as a write to that word returns the word's previous contents. A read issued in the cycle after that write also returns the previous contents.
- R3: Port priority. When several write ports target the same word in one cycle, the word takes the data of the lowest-numbered enabled port (port 0 beats port 1).
- R4: Independent reads. Each read port returns the word selected by its own address, whatever the other read ports select.
- R5: Parallel writes. Writes on different ports to different words in the same cycle all take effect.
- R6: Reset. A write that is sampled while `rst_n` is low does not change the array. Reset does not clear the stored words, so a word written before reset still reads back after it.
- R7: Output hold. With `OUT_LATCH`=1, `rd_data` stays constant through the low phase of the clock, even while the addressed word is being updated.
- R8: Idle. A cycle with no write enable asserted leaves every stored word unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. Word latches open only while it is low. |
| rst_n | input | 1 | Synchronous active-low reset of the write capture stage. |
| wr_en | input | NWR | Write enable, one bit per write port. |
| wr_addr | input | NWR x AW | Word address per write port. |
| wr_data | input | NWR x WIDTH | Write data per write port. |
| rd_addr | input | NRD x AW | Word address per read port. |
| rd_data | output | NRD x WIDTH | Read data per read port. |

## Verification
The hardest situation to reach from the ports is a read whose output latch is holding while the very word it addresses is updated in the same low phase. That happens only when a read targets a word written exactly one cycle earlier. The bench sets this up in directed sequences: it writes a word and reads it on all ports in the same cycle and in the following one. It then samples `rd_data` twice per cycle, once late in the high phase and once late in the low phase, after the latch update. Write-port collisions on one word are forced periodically during the random traffic, so the priority rule is exercised alongside the read-during-write cases.

// File: rtl/lrf_pkg.sv
`timescale 1ns/100ps
// lrf_pkg: shared helpers for the latch register file.
// Assumes: word counts are at least 1.
package lrf_pkg;
    // Address width needed for n words (never below 1 bit).
    function automatic int addr_bits(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction
endpackage

// File: rtl/lrf_wr_capture.sv
`timescale 1ns/100ps
// lrf_wr_capture: rising-edge capture of one write port's request.
// Holds the request stable for the whole following cycle so that the
// low-phase latch update sees glitch-free inputs.
// Assumes: synchronous active-low reset clears only the enable.
module lrf_wr_capture #(
    parameter int AW    = 4,
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [AW-1:0]    addr,
    input  logic [WIDTH-1:0] data,
    output logic             we_q,
    output logic [AW-1:0]    addr_q,
    output logic [WIDTH-1:0] data_q
);
    // Enable flop: cleared by reset so no write lands during reset.
    always_ff @(posedge clk) begin
        if (!rst_n) we_q <= 1'b0;
        else        we_q <= we;
    end

    // Address and data flops: no reset needed, qualified by we_q.
    always_ff @(posedge clk) begin
        addr_q <= addr;
        data_q <= data;
    end
endmodule

// File: rtl/lrf_wr_decode.sv
`timescale 1ns/100ps
// lrf_wr_decode: one-of-N word select for one write port.
// Assumes: inputs come from capture flops and are stable within a cycle.
module lrf_wr_decode #(
    parameter int NWORDS = 16,
    parameter int AW     = 4
) (
    input  logic              we,
    input  logic [AW-1:0]     addr,
    output logic [NWORDS-1:0] sel
);
    // Compare the captured address against each word index.
    always_comb begin
        for (int w = 0; w < NWORDS; w++) begin
            sel[w] = we && (addr == AW'(w));
        end
    end
endmodule

// File: rtl/lrf_word_cell.sv
`timescale 1ns/100ps
// lrf_word_cell: one storage word made of transparent-low latches.
// A priority mux picks the lowest-numbered selecting port. A latch-based
// clock gate (enable latch open while clk is high) produces a word gate
// that pulses only in the low phase.
// Assumes: sel and port_data change only at the rising edge.
module lrf_word_cell #(
    parameter int WIDTH = 8,
    parameter int NWR   = 2
) (
    input  logic                      clk,
    input  logic [NWR-1:0]            sel,
    input  logic [NWR-1:0][WIDTH-1:0] port_data,
    output logic [WIDTH-1:0]          q
);
    logic             hit;
    logic [WIDTH-1:0] d;
    logic             en_lat;
    logic             gate;

    // Priority mux: scan from the top so the lowest port index wins.
    always_comb begin
        hit = 1'b0;
        d   = '0;
        for (int p = NWR - 1; p >= 0; p--) begin
            if (sel[p]) begin
                hit = 1'b1;
                d   = port_data[p];
            end
        end
    end

    // Clock-gate enable latch: follows hit in the high phase, frozen low.
    always_latch begin
        if (clk) en_lat <= hit;
    end

    assign gate = ~clk & en_lat;

    // Storage latch: open only while the gated word clock is active.
    always_latch begin
        if (gate) q <= d;
    end
endmodule

// File: rtl/lrf_rd_port.sv
`timescale 1ns/100ps
// lrf_rd_port: combinational word select with an optional output latch.
// With HOLD set, the output latch is transparent while clk is high and
// holds through the low phase while the array may update.
// Assumes: addr is applied early in the high phase.
module lrf_rd_port #(
    parameter int NWORDS = 16,
    parameter int WIDTH  = 8,
    parameter int AW     = 4,
    parameter bit HOLD   = 1'b1
) (
    input  logic                         clk,
    input  logic [NWORDS-1:0][WIDTH-1:0] words,
    input  logic [AW-1:0]                addr,
    output logic [WIDTH-1:0]             data
);
    logic [WIDTH-1:0] pick;

    // Read mux: index the word array by address.
    always_comb pick = words[addr];

    generate
        if (HOLD) begin : g_hold
            logic [WIDTH-1:0] held;
            // Output latch: pass in the high phase, keep in the low phase.
            always_latch begin
                if (clk) held <= pick;
            end
            assign data = held;
        end else begin : g_direct
            assign data = pick;
        end
    endgenerate
endmodule

// File: rtl/latch_regfile.sv
`timescale 1ns/100ps
// latch_regfile: multiport register file built from latches.
// Write requests are captured per port on the rising edge and are
// written into the latch words during the following low phase. Reads are
// combinational, with an optional holding latch on each output.
// Assumes: the array is not reset; callers write a word before reading it.
module latch_regfile #(
    parameter int NWORDS    = 16,
    parameter int WIDTH     = 8,
    parameter int NWR       = 2,
    parameter int NRD       = 3,
    parameter bit OUT_LATCH = 1'b1,
    localparam int AW       = lrf_pkg::addr_bits(NWORDS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NWR-1:0]            wr_en,
    input  logic [NWR-1:0][AW-1:0]    wr_addr,
    input  logic [NWR-1:0][WIDTH-1:0] wr_data,
    input  logic [NRD-1:0][AW-1:0]    rd_addr,
    output logic [NRD-1:0][WIDTH-1:0] rd_data
);
    logic [NWR-1:0]              we_q;
    logic [NWR-1:0][AW-1:0]      addr_q;
    logic [NWR-1:0][WIDTH-1:0]   data_q;
    logic [NWR-1:0][NWORDS-1:0]  port_sel;
    logic [NWORDS-1:0][NWR-1:0]  word_sel;
    logic [NWORDS-1:0][WIDTH-1:0] word_q;

    // Write side: one capture stage and one decoder per write port.
    generate
        for (genvar p = 0; p < NWR; p++) begin : g_wport
            lrf_wr_capture #(.AW(AW), .WIDTH(WIDTH)) u_cap (
                .clk   (clk),
                .rst_n (rst_n),
                .we    (wr_en[p]),
                .addr  (wr_addr[p]),
                .data  (wr_data[p]),
                .we_q  (we_q[p]),
                .addr_q(addr_q[p]),
                .data_q(data_q[p])
            );
            lrf_wr_decode #(.NWORDS(NWORDS), .AW(AW)) u_dec (
                .we  (we_q[p]),
                .addr(addr_q[p]),
                .sel (port_sel[p])
            );
        end
    endgenerate

    // Storage: regroup the selects per word, then one latch word each.
    generate
        for (genvar w = 0; w < NWORDS; w++) begin : g_word
            for (genvar p = 0; p < NWR; p++) begin : g_tp
                assign word_sel[w][p] = port_sel[p][w];
            end
            lrf_word_cell #(.WIDTH(WIDTH), .NWR(NWR)) u_cell (
                .clk      (clk),
                .sel      (word_sel[w]),
                .port_data(data_q),
                .q        (word_q[w])
            );
        end
    endgenerate

    // Read side: one independent mux per read port.
    generate
        for (genvar r = 0; r < NRD; r++) begin : g_rport
            lrf_rd_port #(.NWORDS(NWORDS), .WIDTH(WIDTH), .AW(AW),
                          .HOLD(OUT_LATCH)) u_rd (
                .clk  (clk),
                .words(word_q),
                .addr (rd_addr[r]),
                .data (rd_data[r])
            );
        end
    endgenerate
endmodule

// File: rtl/lrf_checker.sv
`timescale 1ns/100ps
// lrf_checker: temporal properties for latch_regfile, bound to the top.
// Assumes: mem is the top's latch word array.
module lrf_checker #(
    parameter int NWORDS    = 16,
    parameter int WIDTH     = 8,
    parameter int NWR       = 2,
    parameter int NRD       = 3,
    parameter bit OUT_LATCH = 1'b1,
    parameter int AW        = 4
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [NWR-1:0]               wr_en,
    input logic [NWR-1:0][AW-1:0]       wr_addr,
    input logic [NWR-1:0][WIDTH-1:0]    wr_data,
    input logic [NRD-1:0][AW-1:0]       rd_addr,
    input logic [NRD-1:0][WIDTH-1:0]    rd_data,
    input logic [NWORDS-1:0][WIDTH-1:0] mem
);
    // Port 0 write lands in the array one cycle after it is sampled.
    assert_port0_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en[0] |=> mem[$past(wr_addr[0])] == $past(wr_data[0]));

    // A cycle without write enables leaves the array untouched.
    assert_idle_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(|wr_en) |=> $stable(mem));

    generate
        if (NWR > 1) begin : g_prio
            // Port 1 lands unless port 0 targets the same word.
            assert_port1_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en[1] && !(wr_en[0] && wr_addr[0] == wr_addr[1]))
                |=> mem[$past(wr_addr[1])] == $past(wr_data[1]));
        end

        for (genvar r = 0; r < NRD; r++) begin : g_rd
            // At the end of the high phase every port shows its word.
            assert_read_select_R4: assert property (@(negedge clk) disable iff (!rst_n)
                rd_data[r] == mem[rd_addr[r]]);
        end

        if (OUT_LATCH) begin : g_hold
            logic [NRD-1:0][WIDTH-1:0] rd_at_fall;
            logic                      fall_seen;
            // Record the outputs as the low phase starts.
            always_ff @(negedge clk) begin
                rd_at_fall <= rd_data;
                fall_seen  <= rst_n;
            end
            // The outputs did not move during the low phase.
            assert_out_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
                fall_seen |-> rd_data == rd_at_fall);
        end
    endgenerate
endmodule

bind latch_regfile lrf_checker #(
    .NWORDS(NWORDS), .WIDTH(WIDTH), .NWR(NWR), .NRD(NRD),
    .OUT_LATCH(OUT_LATCH), .AW(AW)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .rd_addr(rd_addr),
    .rd_data(rd_data),
    .mem    (word_q)
);

// File: tb/latch_regfile_tb.sv
`timescale 1ns/100ps
// Scoreboard bench: step() drives one cycle and queues the expected reads.
// The monitor compares them late in the high phase and late in the low phase.
module latch_regfile_tb;
    localparam int NW = 16, W = 8, NWR = 2, NRD = 3, AW = 4;

    logic clk = 1'b0;
    logic rst_n;
    logic [NWR-1:0]          wr_en;
    logic [NWR-1:0][AW-1:0]  wr_addr;
    logic [NWR-1:0][W-1:0]   wr_data;
    logic [NRD-1:0][AW-1:0]  rd_addr;
    logic [NRD-1:0][W-1:0]   rd_data;

    always #2.5 clk = ~clk;

    latch_regfile #(.NWORDS(NW), .WIDTH(W), .NWR(NWR), .NRD(NRD), .OUT_LATCH(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    typedef struct {
        logic [NRD-1:0][W-1:0] exp;
        logic [NRD-1:0]        vld;
        string                 tag;
    } item_t;

    item_t q[$];
    int checks = 0;
    int failures = 0;

    logic [W-1:0] model [NW];
    bit           known [NW];
    bit           nx_rst;
    bit     [NWR-1:0] nx_we;
    int           nx_wa [NWR];
    logic [W-1:0] nx_wd [NWR];
    int           nx_ra [NRD];
    bit     [NWR-1:0] p1_we, p2_we;
    int           p1_a [NWR], p2_a [NWR];
    logic [W-1:0] p1_d [NWR], p2_d [NWR];

    task automatic chk(input string tag, input int r, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s read port %0d actual=%h expected=%h at %0t", tag, r, act, exp, $time);
        end
    endtask

    task automatic idle_next();
        nx_we = '0;
        for (int r = 0; r < NRD; r++) nx_ra[r] = r;
    endtask

    // One cycle: retire the write from two cycles back into the model,
    // apply the new inputs and queue the read expectations.
    task automatic step(input string tag);
        item_t it;
        @(posedge clk);
        #0.5;
        for (int p = NWR - 1; p >= 0; p--) begin
            if (p2_we[p]) begin
                model[p2_a[p]] = p2_d[p];
                known[p2_a[p]] = 1'b1;
            end
        end
        p2_we = p1_we; p2_a = p1_a; p2_d = p1_d;
        for (int p = 0; p < NWR; p++) begin
            p1_we[p] = nx_we[p] & nx_rst;
            p1_a[p]  = nx_wa[p];
            p1_d[p]  = nx_wd[p];
            wr_en[p]   = nx_we[p];
            wr_addr[p] = AW'(nx_wa[p]);
            wr_data[p] = nx_wd[p];
        end
        rst_n = nx_rst;
        for (int r = 0; r < NRD; r++) begin
            rd_addr[r] = AW'(nx_ra[r]);
            it.exp[r]  = model[nx_ra[r]];
            it.vld[r]  = known[nx_ra[r]];
        end
        it.tag = tag;
        q.push_back(it);
    endtask

    // Monitor: compare before the falling edge, then again before the rising edge.
    initial begin
        item_t it;
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                it = q[0];
                for (int r = 0; r < NRD; r++)
                    if (it.vld[r]) chk(it.tag, r, rd_data[r], it.exp[r]);
                #2.5;
                for (int r = 0; r < NRD; r++)
                    if (it.vld[r]) chk("R7", r, rd_data[r], it.exp[r]);
                void'(q.pop_front());
            end
        end
    end

    initial begin
        #(60000 * 5);
        failures++;
        $display("FAIL watchdog R1 actual=hang expected=finish");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 1'b0; wr_en = '0; wr_addr = '0; wr_data = '0; rd_addr = '0;
        p1_we = '0; p2_we = '0;
        for (int p = 0; p < NWR; p++) begin p1_a[p] = 0; p2_a[p] = 0; p1_d[p] = '0; p2_d[p] = '0; end
        for (int w = 0; w < NW; w++) begin model[w] = '0; known[w] = 1'b0; end
        nx_rst = 1'b0;
        for (int p = 0; p < NWR; p++) begin nx_wa[p] = 0; nx_wd[p] = '0; end
        idle_next();
        repeat (3) step("R6");
        nx_rst = 1'b1;

        // R5: fill the array two words per cycle on separate ports.
        for (int i = 0; i < NW / 2; i++) begin
            idle_next();
            nx_we = 2'b11;
            nx_wa[0] = 2 * i;     nx_wd[0] = W'(8'h40 + 2 * i);
            nx_wa[1] = 2 * i + 1; nx_wd[1] = W'(8'hA0 + 2 * i);
            step("R5");
        end
        // R8 and R4: idle cycles, then read everything back on all ports.
        idle_next(); step("R8"); step("R8");
        for (int i = 0; i < NW; i++) begin
            idle_next();
            nx_ra[0] = i; nx_ra[1] = (i + 5) % NW; nx_ra[2] = NW - 1 - i;
            step("R4");
        end

        // R2: write word 5 and read it in the same cycle and the next one.
        idle_next();
        nx_we = 2'b01; nx_wa[0] = 5; nx_wd[0] = 8'h5C;
        for (int r = 0; r < NRD; r++) nx_ra[r] = 5;
        step("R2");
        idle_next(); for (int r = 0; r < NRD; r++) nx_ra[r] = 5;
        step("R2");
        step("R1");
        step("R1");

        // R3: both ports write word 7; port 0 data must remain.
        idle_next();
        nx_we = 2'b11; nx_wa[0] = 7; nx_wd[0] = 8'h11; nx_wa[1] = 7; nx_wd[1] = 8'h22;
        for (int r = 0; r < NRD; r++) nx_ra[r] = 7;
        step("R3");
        idle_next(); for (int r = 0; r < NRD; r++) nx_ra[r] = 7;
        step("R3"); step("R3");

        // R6: writes during reset are dropped, contents survive reset.
        idle_next();
        nx_rst = 1'b0;
        nx_we = 2'b11; nx_wa[0] = 3; nx_wd[0] = 8'hEE; nx_wa[1] = 9; nx_wd[1] = 8'hDD;
        step("R6"); step("R6");
        nx_rst = 1'b1;
        idle_next(); nx_ra[0] = 3; nx_ra[1] = 9; nx_ra[2] = 7;
        step("R6"); step("R6"); step("R6");

        // Random traffic with a forced collision every eighth cycle.
        for (int i = 0; i < 600; i++) begin
            nx_we = NWR'($urandom_range(0, 3));
            for (int p = 0; p < NWR; p++) begin
                nx_wa[p] = $urandom_range(0, NW - 1);
                nx_wd[p] = W'($urandom);
            end
            if (i % 8 == 0) begin nx_we = 2'b11; nx_wa[1] = nx_wa[0]; end
            for (int r = 0; r < NRD; r++) nx_ra[r] = $urandom_range(0, NW - 1);
            if (i % 5 == 0) nx_ra[1] = nx_wa[0];
            step((i % 8 == 0) ? "R3" : "R4");
        end
        idle_next();
        repeat (4) step("R8");
        @(posedge clk); @(posedge clk);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule